// File: doc/BRIEF.md
# Self-Checking Decimal Add/Subtract Unit

This block adds or subtracts two multi-digit packed decimal operands and does not report success until it has proved its own answer. Each decimal digit travels with an even-parity bit. After the forward operation the result is written into a holding word with freshly generated parity. It is then read back, and the opposite operation is run on the read-back copy. The recovered operand must equal the original. A third mode skips the arithmetic: it stores operand A, reads it back and compares it digit by digit against operand B, which acts as a duplicate copy of the same item.

A controller pulses `start` with the operands and the mode. It waits for the one-cycle `done` pulse and then reads the result, the decimal carry or borrow, and a two-bit error code. The result and the code stay put until the next accepted start.

Top module: `bcd_selfcheck_unit`

## Requirements
- R1: With `op` = 00 (add) the result is (A + B) mod 10^NDIG in packed decimal, 4 bits per digit with digit 0 in bits [3:0], and `res_carry` is 1 exactly when A + B reaches 10^NDIG.
- R2: With `op` = 01 (subtract) the result is A − B when A ≥ B, with `res_carry` = 0. When A < B the result is A − B + 10^NDIG (ten's complement), with `res_carry` = 1 as the borrow.
- R3: A digit position whose sum exceeds 9 has 6 added and passes a carry upward, so every result digit formed from decimal inputs lies in 0..9 (for example 55 + 55 = 110).
- R4: `res_par[i]` is the XOR of the four bits of result digit i, so each 5-bit digit holds an even number of ones.
- R5: A parity error on any input digit, or on the read-back word, ends the operation with `err_code` = 01 and `err` = 1. This takes priority over any mismatch.
- R6: When the opposite operation on the read-back result does not recover operand A, the unit ends with `err_code` = 10 and keeps the forward result. This happens, for example, when A holds the non-decimal digit 0xC.
- R7: With `op[1]` = 1 (write-verify) the result is A with `res_carry` = 0. If the read-back copy differs from B in any digit, `err_code` = 11; otherwise `err_code` = 00.
- R8: A start accepted on clock edge E raises `busy` after E. `done` is high for exactly the one cycle that follows edge E+4, and `busy` falls after edge E+5.
- R9: `start` is ignored while `busy` is high. The running operation completes with its own operands, and no extra `done` follows.
- R10: After reset the result, carry, parity, `err_code`, `busy` and `done` are all zero. Result, carry, parity and `err_code` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 2 | 00 add, 01 subtract, 1x write-verify |
| a_dig | input | 4*NDIG | Operand A, packed decimal |
| a_par | input | NDIG | Even-parity bits of A, one per digit |
| b_dig | input | 4*NDIG | Operand B, packed decimal |
| b_par | input | NDIG | Even-parity bits of B |
| res_dig | output | 4*NDIG | Result, packed decimal |
| res_par | output | NDIG | Generated even-parity bits of the result |
| res_carry | output | 1 | Decimal carry (add) or borrow (subtract) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Any error recorded |
| err_code | output | 2 | 00 none, 01 parity, 10 inverse mismatch, 11 write mismatch |

## Verification
Inputs are driven and outputs sampled on falling edges. The start is driven one falling edge before the edge that takes it, so `busy` is checked at the next falling edge, `done` is checked low at the fourth and high at the fifth, and `busy` is checked low at the sixth. The result, carry, parity and error code are read only in the `done` cycle. They are then read again several cycles later with changed inputs, which confirms they hold. For the ignored start, a second start is pulsed in mid-flight, and the bench watches that no second `done` appears and that the first operation's answer arrives on schedule.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COMPUTE, ST_STORE, ST_READBACK, ST_VERIFY, ST_DONE, ST_ERROR
  } seq_state_t;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_PAR  = 2'b01;
  localparam logic [1:0] ERR_INV  = 2'b10;
  localparam logic [1:0] ERR_WR   = 2'b11;

  function automatic logic digit_parity(input logic [3:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       cout
);
  logic [4:0] raw;
  logic [4:0] fixed;

  always_comb begin
    raw   = {1'b0, a} + {1'b0, b} + {4'd0, cin};
    fixed = raw + 5'd6;
    if (raw > 5'd9) begin
      sum  = fixed[3:0];
      cout = 1'b1;
    end else begin
      sum  = raw[3:0];
      cout = 1'b0;
    end
  end

  // R3: decimal inputs always give a decimal digit
  always_comb begin
    if (a <= 4'd9 && b <= 4'd9)
      p_digit_decimal_r3: assert (sum <= 4'd9);
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple #(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [NDIG:0] c;
  assign c[0] = sub;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] b_eff;
    assign b_eff = sub ? (4'd9 - b[i*4 +: 4]) : b[i*4 +: 4];
    bcd_digit_add u_dig (
      .a   (a[i*4 +: 4]),
      .b   (b_eff),
      .cin (c[i]),
      .sum (sum[i*4 +: 4]),
      .cout(c[i+1])
    );
  end

  assign cout = c[NDIG];
endmodule

// File: rtl/bcd_par_chk.sv
module bcd_par_chk #(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0]    dig,
  input  logic [NDIG-1:0] par,
  output logic            bad
);
  logic [NDIG-1:0] odd;
  for (genvar i = 0; i < NDIG; i++) begin : g_chk
    assign odd[i] = ^{par[i], dig[i*4 +: 4]};
  end
  assign bad = |odd;
endmodule

// File: rtl/bcd_selfcheck_unit.sv
module bcd_selfcheck_unit
  import bcd_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [W-1:0]    a_dig,
  input  logic [NDIG-1:0] a_par,
  input  logic [W-1:0]    b_dig,
  input  logic [NDIG-1:0] b_par,
  output logic [W-1:0]    res_dig,
  output logic [NDIG-1:0] res_par,
  output logic            res_carry,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [1:0]      err_code
);
  seq_state_t st;

  logic [W-1:0]    a_q, b_q;
  logic [NDIG-1:0] ap_q, bp_q;
  logic            sub_q, wr_q;
  logic            pfault_q;
  logic [W-1:0]    res_q;
  logic [NDIG-1:0] rpar_q;
  logic            carry_q;
  logic [W-1:0]    store_dig_q, rb_dig_q;
  logic [NDIG-1:0] store_par_q, rb_par_q;
  logic [1:0]      code_q;
  logic            done_q;

  logic [W-1:0]    fwd_sum, inv_sum;
  logic            fwd_cout, inv_cout;
  logic            bad_a, bad_b, bad_rb;
  logic [W-1:0]    next_res;
  logic            next_carry;
  logic [NDIG-1:0] next_par;
  logic            mismatch;

  bcd_ripple #(.NDIG(NDIG)) u_fwd (
    .a(a_q), .b(b_q), .sub(sub_q), .sum(fwd_sum), .cout(fwd_cout)
  );

  bcd_ripple #(.NDIG(NDIG)) u_inv (
    .a(rb_dig_q), .b(b_q), .sub(~sub_q), .sum(inv_sum), .cout(inv_cout)
  );

  bcd_par_chk #(.NDIG(NDIG)) u_chk_a  (.dig(a_q),      .par(ap_q),     .bad(bad_a));
  bcd_par_chk #(.NDIG(NDIG)) u_chk_b  (.dig(b_q),      .par(bp_q),     .bad(bad_b));
  bcd_par_chk #(.NDIG(NDIG)) u_chk_rb (.dig(rb_dig_q), .par(rb_par_q), .bad(bad_rb));

  always_comb begin
    if (wr_q) begin
      next_res   = a_q;
      next_carry = 1'b0;
    end else begin
      next_res   = fwd_sum;
      next_carry = sub_q ? ~fwd_cout : fwd_cout;
    end
    for (int i = 0; i < NDIG; i++)
      next_par[i] = digit_parity(next_res[i*4 +: 4]);
    mismatch = wr_q ? (rb_dig_q != b_q) : (inv_sum != a_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      a_q         <= '0;
      b_q         <= '0;
      ap_q        <= '0;
      bp_q        <= '0;
      sub_q       <= 1'b0;
      wr_q        <= 1'b0;
      pfault_q    <= 1'b0;
      res_q       <= '0;
      rpar_q      <= '0;
      carry_q     <= 1'b0;
      store_dig_q <= '0;
      store_par_q <= '0;
      rb_dig_q    <= '0;
      rb_par_q    <= '0;
      code_q      <= ERR_NONE;
      done_q      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            a_q    <= a_dig;
            b_q    <= b_dig;
            ap_q   <= a_par;
            bp_q   <= b_par;
            sub_q  <= (op == 2'b01);
            wr_q   <= op[1];
            code_q <= ERR_NONE;
            st     <= ST_COMPUTE;
          end
        end
        ST_COMPUTE: begin
          res_q    <= next_res;
          carry_q  <= next_carry;
          rpar_q   <= next_par;
          pfault_q <= bad_a | bad_b;
          st       <= ST_STORE;
        end
        ST_STORE: begin
          store_dig_q <= res_q;
          store_par_q <= rpar_q;
          st          <= ST_READBACK;
        end
        ST_READBACK: begin
          rb_dig_q <= store_dig_q;
          rb_par_q <= store_par_q;
          st       <= ST_VERIFY;
        end
        ST_VERIFY: begin
          done_q <= 1'b1;
          if (pfault_q || bad_rb) begin
            code_q <= ERR_PAR;
            st     <= ST_ERROR;
          end else if (mismatch) begin
            code_q <= wr_q ? ERR_WR : ERR_INV;
            st     <= ST_ERROR;
          end else begin
            st <= ST_DONE;
          end
        end
        default: begin
          done_q <= 1'b0;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  assign res_dig   = res_q;
  assign res_par   = rpar_q;
  assign res_carry = carry_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign err_code  = code_q;
  assign err       = (code_q != ERR_NONE);

  // R8: an accepted start makes the unit busy without completing at once
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start) |=> (busy && !done));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: captured operands never change while an operation runs
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(a_q) && $stable(b_q)));

  // R10: results and code hold while idle without a start
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(res_q) && $stable(code_q) && $stable(carry_q)));

  // R5: an input parity fault always ends with the parity code
  p_parity_code_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_VERIFY && pfault_q) |=> (err_code == ERR_PAR && done));

  // R4: the stored copy read back carries the generated even parity
  p_readback_par_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_VERIFY) |-> !bad_rb);
endmodule

// File: tb/test_bcd_selfcheck_unit.sv
module test_bcd_selfcheck_unit;
  localparam int NDIG = 8;
  localparam int W = 4 * NDIG;
  localparam longint MODV = 64'd100000000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [1:0]      op = 2'b00;
  logic [W-1:0]    a_dig = '0, b_dig = '0;
  logic [NDIG-1:0] a_par = '0, b_par = '0;
  logic [W-1:0]    res_dig;
  logic [NDIG-1:0] res_par;
  logic            res_carry, busy, done, err;
  logic [1:0]      err_code;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_selfcheck_unit #(.NDIG(NDIG)) i_bcd_selfcheck_unit (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .a_dig(a_dig), .a_par(a_par), .b_dig(b_dig), .b_par(b_par),
    .res_dig(res_dig), .res_par(res_par), .res_carry(res_carry),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint to_int(input logic [W-1:0] v);
    longint r = 0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(input longint x);
    logic [W-1:0] v;
    longint t = x;
    for (int i = 0; i < NDIG; i++) begin
      v[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return v;
  endfunction

  function automatic logic [NDIG-1:0] gen_par(input logic [W-1:0] v);
    logic [NDIG-1:0] p;
    for (int i = 0; i < NDIG; i++)
      p[i] = v[i*4] ^ v[i*4+1] ^ v[i*4+2] ^ v[i*4+3];
    return p;
  endfunction

  // drives one operation and checks the R8 timing; returns at the done cycle
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [NDIG-1:0] ap, input logic [NDIG-1:0] bp);
    @(negedge clk);
    op = o; a_dig = a; b_dig = b; a_par = ap; b_par = bp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 done not early", done, 1'b0);
    @(negedge clk);
    check("R8 done at fifth cycle", done, 1'b1);
  endtask

  task automatic finish_op();
    @(negedge clk);
    check("R8 done one cycle", done, 1'b0);
    check("R8 busy cleared", busy, 1'b0);
  endtask

  // op, A, B: expected values come from the integer model
  localparam int NV = 9;
  localparam logic [65:0] VEC [NV] = '{
    {2'b00, 32'h12345678, 32'h87654321},
    {2'b00, 32'h99999999, 32'h00000001},
    {2'b00, 32'h00000999, 32'h00000001},
    {2'b00, 32'h00000055, 32'h00000055},
    {2'b00, 32'h00000000, 32'h00000000},
    {2'b01, 32'h50000000, 32'h00000001},
    {2'b01, 32'h00000003, 32'h00000005},
    {2'b01, 32'h24682468, 32'h24682468},
    {2'b10, 32'h13572468, 32'h13572468}
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset result", res_dig, '0);
    check("R10 reset code", err_code, 2'b00);
    check("R10 reset busy", busy, 1'b0);
    check("R10 reset done", done, 1'b0);
    check("R10 reset carry", res_carry, 1'b0);

    // vector table: R1 add, R2 subtract, R3 correction, R7 write-verify match
    for (int k = 0; k < NV; k++) begin
      logic [1:0]   vo;
      logic [W-1:0] va, vb, er;
      logic         ec;
      longint       ia, ib, s;
      vo = VEC[k][65:64];
      va = VEC[k][63:32];
      vb = VEC[k][31:0];
      ia = to_int(va);
      ib = to_int(vb);
      if (vo[1]) begin
        er = va; ec = 1'b0;
      end else if (vo == 2'b01) begin
        s = ia - ib;
        ec = (s < 0);
        if (s < 0) s = s + MODV;
        er = to_bcd(s);
      end else begin
        s = ia + ib;
        ec = (s >= MODV);
        er = to_bcd(s % MODV);
      end
      run_op(vo, va, vb, gen_par(va), gen_par(vb));
      check(vo[1] ? "R7 write result" : (vo == 2'b01 ? "R2 sub result" : "R1 add result"),
            res_dig, er);
      check(vo == 2'b01 ? "R2 borrow" : "R1 carry", res_carry, ec);
      check("R4 result parity", res_par, gen_par(er));
      check("R3 no error on valid operands", err_code, 2'b00);
      finish_op();
    end

    // R5: parity fault on input, together with a non-decimal digit (priority)
    run_op(2'b00, 32'h0000000C, 32'h00000001, gen_par(32'h0000000C) ^ 8'h01,
           gen_par(32'h00000001));
    check("R5 parity code", err_code, 2'b01);
    check("R5 err flag", err, 1'b1);
    finish_op();

    // R6: non-decimal digit C + 0 gives 12, whose inverse does not recover C
    run_op(2'b00, 32'h0000000C, 32'h00000000, gen_par(32'h0000000C), gen_par(32'h0));
    check("R6 inverse mismatch code", err_code, 2'b10);
    check("R6 result kept", res_dig, 32'h00000012);
    finish_op();
    // R10: outputs hold with changed inputs and no start
    a_dig = 32'h55555555; b_dig = 32'h44444444; op = 2'b01;
    repeat (5) @(negedge clk);
    check("R10 result held", res_dig, 32'h00000012);
    check("R10 code held", err_code, 2'b10);

    // R7: write-verify with differing duplicate copy
    run_op(2'b11, 32'h11111111, 32'h11111112, gen_par(32'h11111111), gen_par(32'h11111112));
    check("R7 write mismatch code", err_code, 2'b11);
    check("R7 write result is A", res_dig, 32'h11111111);
    check("R7 write carry zero", res_carry, 1'b0);
    finish_op();

    // R9: a second start while busy is ignored
    begin
      int extra_done = 0;
      @(negedge clk);
      op = 2'b00; a_dig = 32'h00000021; b_dig = 32'h00000012;
      a_par = gen_par(a_dig); b_par = gen_par(b_dig); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op = 2'b01; a_dig = 32'h00000700; b_dig = 32'h00000300;
      a_par = gen_par(a_dig); b_par = gen_par(b_dig); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 first operation completes", done, 1'b1);
      check("R9 first operands used", res_dig, 32'h00000033);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (done) extra_done++;
      end
      check("R9 no second done", extra_done, 0);
      check("R9 result unchanged", res_dig, 32'h00000033);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule